// File: doc/BRIEF.md
# USB OUT Endpoint Receive Handler

This block takes host-to-device data for up to sixteen endpoints and lands it in one shared byte queue that firmware drains through a read-to-pop register. Firmware arms an endpoint by writing a control byte that carries the endpoint number and an enable flag. The protocol engine presents each OUT token's endpoint number, then the received bytes, then an end-of-packet strobe together with the result of its CRC check. The block answers each OUT with a handshake code: ACK, NAK or STALL.

The queue is 66 bytes deep because the two CRC bytes are kept after the payload. A packet is taken only if the endpoint is armed and not stalled, no DONE event is pending, and the queue is empty. When a good packet is taken, the block sets DONE, records the endpoint number in status, and disarms that endpoint. Firmware must clear DONE and re-arm the endpoint before the next packet can land. A packet that ends with a bad CRC is thrown away silently.

The control flow is a three-state machine. `ST_IDLE` waits for a token. `ST_RECV` stores bytes into the queue. `ST_SKIP` ignores the bytes of a refused packet until its end. The transitions are:
- `ST_IDLE` to `ST_RECV` when the token is accepted.
- `ST_IDLE` to `ST_SKIP` when the token is refused.
- `ST_RECV` to `ST_IDLE` at end of packet, with ACK if the CRC is good and with a discard if it is bad.
- `ST_SKIP` to `ST_IDLE` at end of packet, with NAK or STALL.

A handler reset write sends any state back to `ST_IDLE`.

Top module: `usb_out_rx`

## Requirements
- R1: The queue holds up to 66 bytes in arrival order, CRC bytes included, so an n-byte payload leaves n+2 bytes. Bytes that arrive while the queue is full are dropped.
- R2: A control write that does not set bit 5 takes the endpoint number from bits [3:0] and loads that endpoint's enable flag from bit 4 and its stall flag from bit 6. An OUT to an endpoint whose enable flag is clear and which is not stalled gets NAK.
- R3: An OUT to an armed endpoint while the queue holds any byte gets NAK, and the queue is left unchanged.
- R4: A good packet that is accepted gets ACK, sets DONE, and clears that endpoint's enable flag. A later OUT to the same endpoint gets NAK until the endpoint is re-armed.
- R5: While DONE is pending, every OUT gets NAK. A pulse on `pend_clr` clears DONE, and a new DONE in the same cycle takes precedence over the clear.
- R6: `stat_epno` takes the endpoint number of a packet only when that packet is accepted with a good CRC, and otherwise holds its value.
- R7: A control write with bit 5 set resets the handler. It empties the queue, clears every enable flag and DONE, and returns the machine to idle. Stall flags and `stat_epno` are kept.
- R8: An accepted packet whose end-of-packet carries `rx_crc_ok` = 0 gets no handshake. The queue returns to empty and DONE is not raised.
- R9: An OUT to a stalled endpoint gets STALL, even if its enable flag is set.
- R10: Handshake encoding:
  - `hs_valid` pulses for one cycle, in the cycle after the end-of-packet cycle.
  - `hs_code` is 1 for ACK, 2 for NAK and 3 for STALL.
- R11: Read side and interrupt:
  - `stat_have` is 1 exactly when the queue is non-empty.
  - `data_rdata` shows the oldest byte, and `data_rd` removes it. A read of an empty queue is ignored.
  - `irq` equals DONE AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control byte: [3:0] endpoint, [4] enable, [5] handler reset, [6] stall |
| pend_clr | input | 1 | Clears the DONE pending event |
| irq_en | input | 1 | DONE interrupt enable |
| data_rd | input | 1 | Pop the head byte of the queue |
| data_rdata | output | 8 | Head byte of the queue |
| stat_epno | output | 4 | Endpoint of the last good packet |
| stat_have | output | 1 | Queue holds data |
| stat_pend | output | 1 | DONE pending |
| irq | output | 1 | Interrupt request |
| tok_valid | input | 1 | OUT token strobe |
| tok_ep | input | 4 | Endpoint of the OUT token |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe (carries no byte) |
| rx_crc_ok | input | 1 | CRC result, valid with rx_eop |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | Handshake: 1 ACK, 2 NAK, 3 STALL |

## Verification
Directed packets are sent in turn to a disarmed endpoint, to an armed endpoint while the queue holds data, while DONE is pending, to a stalled-and-armed endpoint, and with a bad CRC. In each case only one admission condition fails, so each handshake result points to a single gate. Payloads of zero, 64 and 68 bytes separate correct CRC-byte retention from overflow handling. A long random mix of arm, stall, reset, drain and clear operations with random payload lengths and random CRC outcomes is then compared against a bench model. That run exposes ordering faults, such as arm-then-DONE and stall-then-unstall, that the directed cases do not reach.

// File: rtl/out_rx_pkg.sv
package out_rx_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_SKIP
    } rx_state_e;

    localparam int CTL_EN_BIT    = 4;
    localparam int CTL_RST_BIT   = 5;
    localparam int CTL_STALL_BIT = 6;
endpackage

// File: rtl/out_rx_queue.sv
module out_rx_queue #(
    parameter int DEPTH = 66,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
endmodule

// File: rtl/out_rx_eptab.sv
module out_rx_eptab #(
    parameter int NUM_EP = 16,
    parameter int EPW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [EPW-1:0]    wr_ep,
    input  logic              wr_en,
    input  logic              wr_stall,
    input  logic              clr_all,
    input  logic              disarm,
    input  logic [EPW-1:0]    disarm_ep,
    input  logic [EPW-1:0]    look_ep,
    output logic              look_en,
    output logic              look_stall,
    output logic [NUM_EP-1:0] en_vec
);
    logic [NUM_EP-1:0] stall_vec;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_vec[i]    <= 1'b0;
                stall_vec[i] <= 1'b0;
            end else begin
                if (clr_all)
                    en_vec[i] <= 1'b0;
                else if (disarm && disarm_ep == EPW'(i))
                    en_vec[i] <= 1'b0;
                else if (wr && wr_ep == EPW'(i))
                    en_vec[i] <= wr_en;
                if (wr && wr_ep == EPW'(i))
                    stall_vec[i] <= wr_stall;
            end
        end
    end

    assign look_en    = en_vec[look_ep];
    assign look_stall = stall_vec[look_ep];

    AST_CLR_ALL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (en_vec == '0)); // R7
endmodule

// File: rtl/out_rx_fsm.sv
module out_rx_fsm
    import out_rx_pkg::*;
#(
    parameter int EPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tok_valid,
    input  logic [EPW-1:0] tok_ep,
    input  logic           rx_valid,
    input  logic           rx_eop,
    input  logic           rx_crc_ok,
    input  logic           soft_rst,
    input  logic           pend_clr,
    input  logic           ep_en_hit,
    input  logic           ep_stall_hit,
    input  logic           q_empty,
    output logic           q_push,
    output logic           q_flush,
    output logic           disarm,
    output logic [EPW-1:0] disarm_ep,
    output logic           hs_valid,
    output logic [1:0]     hs_code,
    output logic           pend,
    output logic [EPW-1:0] stat_epno
);
    rx_state_e      state_q, state_d;
    hs_e            verdict_q, hs_q;
    logic           hsv_q, pend_q;
    logic [EPW-1:0] cur_q, epno_q;
    logic           tok_take, go_recv, good_end, bad_end, skip_end;

    always_comb begin
        tok_take = tok_valid && (state_q == ST_IDLE);
        go_recv  = tok_take && !ep_stall_hit && ep_en_hit && !pend_q && q_empty;
        good_end = (state_q == ST_RECV) && rx_eop && rx_crc_ok;
        bad_end  = (state_q == ST_RECV) && rx_eop && !rx_crc_ok;
        skip_end = (state_q == ST_SKIP) && rx_eop;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (tok_take) state_d = go_recv ? ST_RECV : ST_SKIP;
            ST_RECV: if (rx_eop)   state_d = ST_IDLE;
            ST_SKIP: if (rx_eop)   state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
        if (soft_rst) state_d = ST_IDLE;
        q_push    = (state_q == ST_RECV) && rx_valid && !soft_rst;
        q_flush   = bad_end || soft_rst;
        disarm    = good_end && !soft_rst;
        disarm_ep = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= HS_NAK;
            hs_q      <= HS_NONE;
            hsv_q     <= 1'b0;
            pend_q    <= 1'b0;
            cur_q     <= '0;
            epno_q    <= '0;
        end else begin
            hsv_q <= !soft_rst && (good_end || skip_end);
            hs_q  <= good_end ? HS_ACK : verdict_q;
            if (tok_take)
                verdict_q <= ep_stall_hit ? HS_STALL : HS_NAK;
            if (go_recv)
                cur_q <= tok_ep;
            if (soft_rst)
                pend_q <= 1'b0;
            else if (good_end)
                pend_q <= 1'b1;
            else if (pend_clr)
                pend_q <= 1'b0;
            if (good_end && !soft_rst)
                epno_q <= cur_q;
        end
    end

    assign hs_valid  = hsv_q;
    assign hs_code   = hsv_q ? hs_q : HS_NONE;
    assign pend      = pend_q;
    assign stat_epno = epno_q;

    AST_ACK_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_ACK) |-> pend); // R4
    AST_NAK_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && state_q == ST_IDLE && pend_q) |=> (state_q != ST_RECV)); // R5
    AST_EPNO_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_epno) |-> (hs_valid && hs_code == HS_ACK)); // R6
    AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_end |=> (!hs_valid && q_empty)); // R8
    AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_take && ep_stall_hit && !soft_rst) |=> (state_q == ST_SKIP && verdict_q == HS_STALL)); // R9
    AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid); // R10
endmodule

// File: rtl/usb_out_rx.sv
module usb_out_rx
    import out_rx_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int DEPTH  = 66
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       pend_clr,
    input  logic       irq_en,
    input  logic       data_rd,
    output logic [7:0] data_rdata,
    output logic [3:0] stat_epno,
    output logic       stat_have,
    output logic       stat_pend,
    output logic       irq,
    input  logic       tok_valid,
    input  logic [3:0] tok_ep,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_eop,
    input  logic       rx_crc_ok,
    output logic       hs_valid,
    output logic [1:0] hs_code
);
    localparam int EPW = $clog2(NUM_EP);

    logic              soft_rst, cfg_wr;
    logic              q_push, q_flush, q_empty, q_full;
    logic              disarm, en_hit, stall_hit;
    logic [EPW-1:0]    disarm_ep;
    logic [NUM_EP-1:0] en_vec;

    assign soft_rst = ctl_wr && ctl_wdata[CTL_RST_BIT];
    assign cfg_wr   = ctl_wr && !ctl_wdata[CTL_RST_BIT];

    out_rx_eptab #(.NUM_EP(NUM_EP), .EPW(EPW)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .wr_ep(ctl_wdata[EPW-1:0]),
        .wr_en(ctl_wdata[CTL_EN_BIT]), .wr_stall(ctl_wdata[CTL_STALL_BIT]),
        .clr_all(soft_rst), .disarm(disarm), .disarm_ep(disarm_ep),
        .look_ep(tok_ep[EPW-1:0]), .look_en(en_hit), .look_stall(stall_hit),
        .en_vec(en_vec)
    );

    out_rx_queue #(.DEPTH(DEPTH), .W(8)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .wdata(rx_byte), .pop(data_rd), .flush(q_flush),
        .rdata(data_rdata), .empty(q_empty), .full(q_full)
    );

    out_rx_fsm #(.EPW(EPW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_ep(tok_ep[EPW-1:0]),
        .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
        .soft_rst(soft_rst), .pend_clr(pend_clr),
        .ep_en_hit(en_hit), .ep_stall_hit(stall_hit), .q_empty(q_empty),
        .q_push(q_push), .q_flush(q_flush),
        .disarm(disarm), .disarm_ep(disarm_ep),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .pend(stat_pend), .stat_epno(stat_epno)
    );

    assign stat_have = !q_empty;
    assign irq       = stat_pend && irq_en;

    AST_ACK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_ACK) |-> !en_vec[stat_epno]); // R4
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> stat_have); // R1
endmodule

// File: tb/usb_out_rx_test.sv
`timescale 1ns/1ps
module usb_out_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 0, pend_clr = 0, irq_en = 0, data_rd = 0;
    logic [7:0] ctl_wdata = 0;
    logic [7:0] data_rdata;
    logic [3:0] stat_epno;
    logic       stat_have, stat_pend, irq;
    logic       tok_valid = 0, rx_valid = 0, rx_eop = 0, rx_crc_ok = 0;
    logic [3:0] tok_ep = 0;
    logic [7:0] rx_byte = 0;
    logic       hs_valid;
    logic [1:0] hs_code;

    always #2 clk = ~clk;

    usb_out_rx uut (.*);

    int n_run = 0, n_fail = 0, cycles = 0;

    logic       m_en [16];
    logic       m_st [16];
    logic       m_pend = 0;
    logic [3:0] m_epno = 0;
    logic [7:0] mq [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_hs(input int ep, input bit good, output bit acc);
        acc = 0;
        if (m_st[ep]) return 3;
        if (m_en[ep] && !m_pend && mq.size() == 0) begin
            acc = 1;
            return good ? 1 : 0;
        end
        return 2;
    endfunction

    task automatic ctl(input int ep, input bit en, input bit st);
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = {1'b0, st, 1'b0, en, ep[3:0]};
        @(negedge clk);
        ctl_wr = 0;
        m_en[ep] = en; m_st[ep] = st;
    endtask

    task automatic soft_reset();
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = 8'h20;
        @(negedge clk);
        ctl_wr = 0;
        foreach (m_en[i]) m_en[i] = 0;
        m_pend = 0; mq.delete();
    endtask

    task automatic clear_pend();
        @(negedge clk); pend_clr = 1;
        @(negedge clk); pend_clr = 0;
        m_pend = 0;
    endtask

    task automatic pkt(input int ep, input int n, input bit good, input string req);
        bit acc; int exp; int act;
        exp = model_hs(ep, good, acc);
        @(negedge clk);
        tok_valid = 1; tok_ep = ep[3:0];
        @(negedge clk);
        tok_valid = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = 8'($urandom);
            if (acc && mq.size() < 66) mq.push_back(rx_byte);
            @(negedge clk);
        end
        rx_valid = 0;
        rx_eop = 1; rx_crc_ok = good;
        @(negedge clk);
        rx_eop = 0;
        act = hs_valid ? int'(hs_code) : 0;
        chk(act == exp, req, act, exp);
        if (acc && good) begin
            m_pend = 1; m_en[ep] = 0; m_epno = ep[3:0];
        end else if (acc) mq.delete();
        chk(stat_pend == m_pend, "R5 pend", stat_pend, m_pend);
        chk(stat_epno == m_epno, "R6 epno", stat_epno, m_epno);
        chk(stat_have == (mq.size() != 0), "R11 have", stat_have, mq.size() != 0);
    endtask

    task automatic drain(input string req);
        while (mq.size() != 0) begin
            @(negedge clk);
            chk(stat_have == 1, "R11 have", stat_have, 1);
            chk(data_rdata == mq[0], req, data_rdata, mq[0]);
            data_rd = 1;
            @(negedge clk);
            data_rd = 0;
            void'(mq.pop_front());
        end
        @(negedge clk);
        chk(stat_have == 0, "R11 empty", stat_have, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'h5eed_0042));
        foreach (m_en[i]) begin m_en[i] = 0; m_st[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(stat_have == 0 && stat_pend == 0 && hs_valid == 0 && irq == 0, "reset", 0, 0);
        chk(stat_epno == 0, "reset epno", stat_epno, 0);

        pkt(3, 4, 1, "R2 disarmed NAK");
        ctl(3, 1, 0);
        pkt(3, 6, 1, "R4 ACK");
        irq_en = 1;
        @(negedge clk);
        chk(irq == 1, "R11 irq", irq, 1);
        irq_en = 0;
        @(negedge clk);
        chk(irq == 0, "R11 irq masked", irq, 0);
        ctl(3, 1, 0);
        pkt(3, 3, 1, "R5 NAK while pend");
        clear_pend();
        cnt = mq.size();
        pkt(3, 3, 1, "R3 NAK queue busy");
        chk(mq.size() == cnt, "R3 queue unchanged", mq.size(), cnt);
        drain("R1 order");
        pkt(3, 2, 1, "R3 ACK when empty");
        drain("R1 order");
        clear_pend();
        pkt(3, 2, 1, "R4 disarmed after ACK");

        ctl(5, 1, 1);
        pkt(5, 4, 1, "R9 STALL over enable");
        ctl(5, 1, 0);
        pkt(5, 4, 1, "R9 unstall ACK");
        drain("R1 order"); clear_pend();

        ctl(2, 1, 0);
        pkt(2, 8, 0, "R8 bad CRC silent");
        pkt(2, 8, 1, "R8 retry ACK");
        drain("R1 order"); clear_pend();

        ctl(7, 1, 0);
        pkt(7, 66, 1, "R1 full packet");
        chk(mq.size() == 66, "R1 66 bytes", mq.size(), 66);
        drain("R1 full order"); clear_pend();
        ctl(7, 1, 0);
        pkt(7, 70, 1, "R1 overflow");
        drain("R1 overflow kept"); clear_pend();
        ctl(0, 1, 0);
        pkt(0, 2, 1, "R1 empty payload");
        chk(mq.size() == 2, "R1 2 bytes", mq.size(), 2);

        ctl(4, 1, 0);
        soft_reset();
        @(negedge clk);
        chk(stat_have == 0 && stat_pend == 0, "R7 reset clears", stat_have, 0);
        chk(stat_epno == 0, "R7 epno kept", stat_epno, 0);
        pkt(4, 2, 1, "R7 enables cleared");

        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 9);
            int ep = $urandom_range(0, 15);
            if (op < 3)       ctl(ep, 1, ($urandom_range(0, 5) == 0));
            else if (op == 3) ctl(ep, $urandom_range(0, 1), 0);
            else if (op < 7)  pkt(ep, $urandom_range(2, 12), ($urandom_range(0, 6) != 0), "R10 random");
            else if (op == 7) drain("R11 random data");
            else if (op == 8) clear_pend();
            else if ($urandom_range(0, 9) == 0) soft_reset();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule